// File: doc/BRIEF.md
# Single-Wire Byte Transfer Engine with Strong Pull-Up

The engine sits between a byte-level command source and a bit-slot timing generator on a single-wire open-drain bus. A byte command selects one of three transfers. A write sends eight write slots. A read issues eight read slots and builds a byte from the sampled levels. A touch writes each bit and records the level sampled in the same slot. The engine issues one slot request at a time and waits for the generator to report the end of the slot and the sampled level before it issues the next.

A one-shot strong pull-up can be armed with a duration in milliseconds. On the next write, the engine turns the strong pull-up on just before the final bit goes out. It holds the pull-up for the armed number of milliseconds after that bit, then drops it. When the hold ends, the engine clears the request and reports the byte as finished. If the bus driver has no strong pull-up available, the engine still waits the same time before it reports completion. A millisecond tick is derived from the clock through a prescaler parameter.

Top module: `sbe_byte_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `spu_on` is 0, `slot_req` is 0 and `rsp_valid` is 0. After reset release, `cmd_ready` is 1 and no strong pull-up request is pending. Asserting reset during a hold drops `spu_on` at once.
- R2: A write (`cmd_op` = 2'b00) issues eight one-cycle `slot_req` pulses. Bit i of `cmd_data` goes out on pulse i, least significant bit first. A pulse is never issued before `slot_done` has ended the previous slot.
- R3: A read (`cmd_op` = 2'b01) issues eight slots with `slot_bit` = 1. The `slot_sample` of slot i lands in bit i of `rsp_data`.
- R4: A touch (`cmd_op` = 2'b10) sends bit i of `cmd_data` in slot i. The `slot_sample` of that slot replaces bit i in `rsp_data`. For a write, `rsp_data` also holds the sampled levels.
- R5: Code 2'b11 on `cmd_op` is ignored. It issues no slot and produces no response.
- R6: A write that starts with a nonzero pending duration and `spu_en` = 1 raises `spu_on` in the cycle of the eighth `slot_req`. `spu_on` is 0 at the first seven. From the cycle after it rises until it falls, no slot is requested.
- R7: Let N be the pending duration and T be `TICKS_PER_MS`. After the `slot_done` that ends the final bit of such a write, `spu_on` stays 1 for exactly N*T cycles. It falls in the cycle in which `rsp_valid` is 1. `rsp_valid` comes N*T+1 cycles after that `slot_done` cycle.
- R8: The pull-up request is consumed by the write that uses it. A later write, or any write with nothing pending, gives `rsp_valid` one cycle after the final `slot_done`.
- R9: A pulse on `arm_valid` with `arm_ms` = 0 cancels a pending request.
- R10: With `spu_en` = 0, a write with a pending duration keeps `spu_on` at 0. It still delays `rsp_valid` by N*T+1 cycles and consumes the request.
- R11: Reads and touches neither drive `spu_on` nor consume a pending request.
- R12: `arm_valid` takes effect only while `cmd_ready` is 1. A pulse during a transfer is ignored.
- R13: `rsp_valid` is a one-cycle pulse. `cmd_ready` is 0 from the cycle after a command is accepted until the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Byte command present |
| cmd_op | input | 2 | 00 write, 01 read, 10 touch, 11 ignored |
| cmd_data | input | DATA_W | Byte to send (write and touch) |
| cmd_ready | output | 1 | Engine idle, command and arm accepted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Sampled levels, slot i at bit i |
| arm_valid | input | 1 | Load the pull-up duration |
| arm_ms | input | MS_W | Duration in milliseconds, 0 cancels |
| spu_en | input | 1 | Bus driver has a strong pull-up |
| slot_req | output | 1 | One-cycle request for a bit slot |
| slot_bit | output | 1 | Level to write in the requested slot (1 = release) |
| slot_done | input | 1 | Slot finished, sample valid |
| slot_sample | input | 1 | Level sampled in the slot |
| spu_on | output | 1 | Strong pull-up drive |

## Verification
If the bit index or the shift register were wrong, bits would come out of order or shifted in position. That shows on `slot_bit` within the first eight slots, and in `rsp_data` at the end of the same byte. If the pending register were wrong, the fault shows on the next write. `spu_on` would rise at the wrong slot or not at all, or the pull-up would be reused on a second write, and the gap from the last `slot_done` to `rsp_valid` would be off by a multiple of the tick count. A prescaler or millisecond counter error shows only as a hold length different from N*T cycles, so the bench measures that gap to the exact cycle for several durations, including 1 ms.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_TOUCH = 2'b10,
    OP_RSVD  = 2'b11
  } sbe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } sbe_state_e;

endpackage

// File: rtl/sbe_rst_sync.sv
module sbe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sbe_bit_shifter.sv
module sbe_bit_shifter #(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              sample,
  output logic              cur_bit,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = load_data;
      idx_d = '0;
    end else if (shift_en) begin
      sh_d  = {sample, sh_q[DATA_W-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load || shift_en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign cur_bit = sh_q[0];
  assign idx     = idx_q;
  assign data    = sh_q;

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift_en)); // R2

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0)); // R2

endmodule

// File: rtl/sbe_hold_timer.sv
module sbe_hold_timer #(
  parameter int MS_W         = 16,
  parameter int TICKS_PER_MS = 200000,
  localparam int TICK_W      = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] load_ms,
  output logic            running,
  output logic            done
);

  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]   MS_ONE    = MS_W'(1);

  logic              run_q, run_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [MS_W-1:0]   ms_q, ms_d;
  logic              tick_wrap;

  assign tick_wrap = run_q && (tick_q == TICK_LAST);
  assign done      = tick_wrap && (ms_q == MS_ONE);

  always_comb begin
    run_d  = run_q;
    tick_d = tick_q;
    ms_d   = ms_q;
    if (load) begin
      run_d  = 1'b1;
      tick_d = '0;
      ms_d   = load_ms;
    end else if (run_q) begin
      if (tick_wrap) begin
        tick_d = '0;
        ms_d   = ms_q - 1'b1;
        if (done) begin
          run_d = 1'b0;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      ms_q   <= '0;
    end else if (load || run_q) begin
      run_q  <= run_d;
      tick_q <= tick_d;
      ms_q   <= ms_d;
    end
  end

  assign running = run_q;

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_ms != '0)); // R7

  AST_RUN_MS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ms_q != '0)); // R7

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !run_q); // R7

endmodule

// File: rtl/sbe_pullup_ctrl.sv
module sbe_pullup_ctrl #(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_en,
  input  logic [MS_W-1:0] arm_ms,
  input  logic            take,
  input  logic            set_on,
  input  logic            clr_on,
  output logic [MS_W-1:0] pend_ms,
  output logic            pend_nz,
  output logic            spu_on
);

  logic [MS_W-1:0] pend_q, pend_d;
  logic            on_q, on_d;

  always_comb begin
    pend_d = pend_q;
    if (take) begin
      pend_d = '0;
    end else if (arm_en) begin
      pend_d = arm_ms;
    end
  end

  always_comb begin
    on_d = on_q;
    if (clr_on) begin
      on_d = 1'b0;
    end else if (set_on) begin
      on_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (take || arm_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
    end else if (set_on || clr_on) begin
      on_q <= on_d;
    end
  end

  assign pend_ms = pend_q;
  assign pend_nz = |pend_q;
  assign spu_on  = on_q;

  AST_SET_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    set_on |-> pend_nz); // R6

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pend_q == '0)); // R8

  AST_ARM_NOT_IN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && arm_en)); // R12

endmodule

// File: rtl/sbe_byte_engine.sv
module sbe_byte_engine #(
  parameter int DATA_W       = 8,
  parameter int MS_W         = 16,
  parameter int TICKS_PER_MS = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              arm_valid,
  input  logic [MS_W-1:0]   arm_ms,
  input  logic              spu_en,
  output logic              slot_req,
  output logic              slot_bit,
  input  logic              slot_done,
  input  logic              slot_sample,
  output logic              spu_on
);
  import sbe_pkg::*;

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(DATA_W - 2);

  logic rst_s_n;

  sbe_state_e st_q, st_d;
  sbe_op_e    op_q, op_d;

  logic              sh_load, sh_shift, sh_bit;
  logic [IDX_W-1:0]  sh_idx;
  logic [DATA_W-1:0] sh_data;

  logic            tm_load, tm_run, tm_done;
  logic            pu_arm, pu_take, pu_set, pu_clr, pu_nz;
  logic [MS_W-1:0] pu_ms;
  logic            is_write;

  sbe_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sbe_bit_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (sh_load),
    .load_data (cmd_data),
    .shift_en  (sh_shift),
    .sample    (slot_sample),
    .cur_bit   (sh_bit),
    .idx       (sh_idx),
    .data      (sh_data)
  );

  sbe_hold_timer #(.MS_W(MS_W), .TICKS_PER_MS(TICKS_PER_MS)) i_timer (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (tm_load),
    .load_ms (pu_ms),
    .running (tm_run),
    .done    (tm_done)
  );

  sbe_pullup_ctrl #(.MS_W(MS_W)) i_pullup (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .arm_en  (pu_arm),
    .arm_ms  (arm_ms),
    .take    (pu_take),
    .set_on  (pu_set),
    .clr_on  (pu_clr),
    .pend_ms (pu_ms),
    .pend_nz (pu_nz),
    .spu_on  (spu_on)
  );

  assign is_write = (op_q == OP_WRITE);
  assign pu_arm   = arm_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    tm_load  = 1'b0;
    pu_take  = 1'b0;
    pu_set   = 1'b0;
    pu_clr   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid && (sbe_op_e'(cmd_op) != OP_RSVD)) begin
          sh_load = 1'b1;
          op_d    = sbe_op_e'(cmd_op);
          st_d    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (slot_done) begin
          sh_shift = 1'b1;
          if (sh_idx == IDX_LAST) begin
            if (is_write && pu_nz) begin
              tm_load = 1'b1;
              pu_take = 1'b1;
              st_d    = ST_HOLD;
            end else begin
              st_d = ST_DONE;
            end
          end else begin
            st_d = ST_ISSUE;
            if ((sh_idx == IDX_PRE) && is_write && pu_nz && spu_en) begin
              pu_set = 1'b1;
            end
          end
        end
      end
      ST_HOLD: begin
        if (tm_done) begin
          pu_clr = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_WRITE;
    end else begin
      st_q <= st_d;
      if (sh_load) begin
        op_q <= op_d;
      end
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign slot_req  = (st_q == ST_ISSUE);
  assign slot_bit  = (op_q == OP_READ) ? 1'b1 : sh_bit;
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_data  = sh_data;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |=> !rsp_valid); // R13

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    slot_req |=> !slot_req); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    slot_req |-> !cmd_ready); // R13

  AST_SPU_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (spu_on && $past(spu_on)) |-> !slot_req); // R6

  AST_SPU_RISE_AT_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(spu_on) |-> slot_req); // R6

  AST_SPU_FALL_RSP: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(spu_on) |-> rsp_valid); // R7

  AST_HOLD_TIMER_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_HOLD) |-> tm_run); // R7

endmodule

// File: tb/test_sbe_byte_engine.sv
`timescale 1ns/1ps
module test_sbe_byte_engine;

  localparam int T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_data = 8'h00;
  logic        cmd_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic        arm_valid = 1'b0;
  logic [15:0] arm_ms = 16'h0;
  logic        spu_en = 1'b0;
  logic        slot_req, slot_bit;
  logic        slot_done = 1'b0;
  logic        slot_sample = 1'b0;
  logic        spu_on;

  sbe_byte_engine #(.DATA_W(8), .MS_W(16), .TICKS_PER_MS(T)) i_sbe_byte_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .arm_valid(arm_valid), .arm_ms(arm_ms),
    .spu_en(spu_en), .slot_req(slot_req), .slot_bit(slot_bit),
    .slot_done(slot_done), .slot_sample(slot_sample), .spu_on(spu_on)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int nbit = 0;
  int rsp_cyc = 0;
  int last_cyc = 0;
  int post_cnt = 0;
  int gen_cnt = 0;
  int exp_pend = 0;
  bit rsp_seen = 0;
  bit gen_busy = 0;
  bit extra_req = 0;
  bit spu_at_rsp = 0;
  logic       bit_l = 1'b0;
  logic [7:0] pat_r = 8'h00;
  logic [7:0] req_bits = 8'h00;
  logic [7:0] req_spu = 8'h00;
  logic [7:0] rsp_dat = 8'h00;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sent(input logic [1:0] op, input logic [7:0] d);
    return (op == 2'b01) ? 8'hFF : d;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  // slot generator model and response monitor
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      gen_busy  = 0;
      slot_done = 1'b0;
    end else begin
      if (rsp_valid) begin
        rsp_cyc    = cyc;
        rsp_dat    = rsp_data;
        spu_at_rsp = spu_on;
        rsp_seen   = 1;
      end else if (nbit == 8 && cyc > last_cyc && spu_on) begin
        post_cnt++;
      end
      slot_done = 1'b0;
      if (slot_req) begin
        if (nbit < 8) begin
          req_bits[nbit] = slot_bit;
          req_spu[nbit]  = spu_on;
        end else begin
          extra_req = 1;
        end
        bit_l    = slot_bit;
        gen_busy = 1;
        gen_cnt  = $urandom_range(0, 3);
      end else if (gen_busy) begin
        if (gen_cnt == 0) begin
          slot_sample = bit_l & pat_r[nbit[2:0]];
          slot_done   = 1'b1;
          gen_busy    = 0;
          if (nbit == 7) last_cyc = cyc;
          nbit++;
        end else begin
          gen_cnt--;
        end
      end
    end
  end

  task automatic clear_book(input logic [7:0] p);
    @(posedge clk); #1;
    nbit = 0; rsp_seen = 0; post_cnt = 0; extra_req = 0;
    req_bits = 8'h00; req_spu = 8'h00; pat_r = p;
  endtask

  task automatic arm(input int ms);
    @(negedge clk);
    arm_valid = 1'b1; arm_ms = 16'(ms);
    @(negedge clk);
    arm_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] d,
                        input logic [7:0] p, input logic en);
    bit hold;
    bit on;
    int ms;
    hold = (op == 2'b00) && (exp_pend != 0);
    on   = hold && en;
    ms   = hold ? exp_pend : 0;
    clear_book(p);
    spu_en = en;
    send_cmd(op, d);
    wait (rsp_seen);
    chk(req_bits == exp_sent(op, d), "R2 slot bit order", req_bits, exp_sent(op, d));
    chk(rsp_dat == (exp_sent(op, d) & p), (op == 2'b01) ? "R3 read data" : "R4 sampled data",
        rsp_dat, exp_sent(op, d) & p);
    chk(req_spu == {on, 7'b0}, (op == 2'b00) ? "R6 pull-up at last bit" : "R11 no pull-up",
        req_spu, {on, 7'b0});
    chk(rsp_cyc - last_cyc == ms * T + 1, hold ? (en ? "R7 hold delay" : "R10 wait without pull-up")
        : "R8 no hold", rsp_cyc - last_cyc, ms * T + 1);
    chk(post_cnt == (on ? ms * T : 0) && !spu_at_rsp, "R7 pull-up cycles", post_cnt, on ? ms * T : 0);
    chk(!extra_req, "R2 slot count", extra_req, 0);
    if (hold) exp_pend = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!spu_on && !slot_req && !rsp_valid, "R1 outputs in reset", {spu_on, slot_req, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !spu_on && !rsp_valid, "R1 idle after reset", {cmd_ready, spu_on, rsp_valid}, 3'b100);

    // directed corner cases
    run_op(2'b00, 8'hA5, 8'hFF, 1'b1);           // R2 plain write
    run_op(2'b01, 8'h00, 8'h3C, 1'b1);           // R3 read
    run_op(2'b10, 8'hF0, 8'h96, 1'b1);           // R4 touch
    arm(3); exp_pend = 3;
    run_op(2'b00, 8'h81, 8'hFF, 1'b1);           // R6 R7
    run_op(2'b00, 8'h81, 8'hFF, 1'b1);           // R8 consumed
    arm(1); exp_pend = 1;
    run_op(2'b00, 8'h7E, 8'hFF, 1'b1);           // R7 one ms
    arm(4); arm(0); exp_pend = 0;
    run_op(2'b00, 8'h55, 8'hFF, 1'b1);           // R9 cancelled
    arm(2); exp_pend = 2;
    run_op(2'b00, 8'h0F, 8'hFF, 1'b0);           // R10 no drive, still waits
    arm(2); exp_pend = 2;
    run_op(2'b01, 8'h00, 8'hA9, 1'b1);           // R11 read leaves request
    run_op(2'b10, 8'h33, 8'hFF, 1'b1);           // R11 touch leaves request
    run_op(2'b00, 8'hC3, 8'hFF, 1'b1);           // request still used

    // R12 arm during a transfer is ignored
    clear_book(8'hFF);
    spu_en = 1'b1;
    send_cmd(2'b00, 8'h12);
    arm(5);
    wait (rsp_seen);
    run_op(2'b00, 8'h34, 8'hFF, 1'b1);           // R12 expects no hold

    // R5 reserved code
    clear_book(8'hFF);
    send_cmd(2'b11, 8'hFF);
    repeat (20) @(negedge clk);
    chk(nbit == 0 && !rsp_seen && cmd_ready, "R5 reserved ignored", nbit, 0);

    // R1 reset during hold
    arm(5); exp_pend = 5;
    clear_book(8'hFF);
    spu_en = 1'b1;
    send_cmd(2'b00, 8'h99);
    wait (nbit == 8);
    repeat (3) @(negedge clk);
    chk(spu_on == 1'b1, "R6 pull-up in hold", spu_on, 1);
    rst_n = 1'b0;
    #0.5;
    chk(spu_on == 1'b0, "R1 reset drops pull-up", spu_on, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_pend = 0;
    repeat (4) @(negedge clk);
    chk(cmd_ready, "R1 ready after reset", cmd_ready, 1);
    run_op(2'b00, 8'h99, 8'hFF, 1'b1);           // R1 request gone

    // constrained random
    for (int k = 0; k < 30; k++) begin
      logic [1:0] op;
      if ($urandom_range(0, 2) == 0) begin
        int ms;
        ms = $urandom_range(0, 4);
        arm(ms);
        exp_pend = ms;
      end
      op = 2'($urandom_range(0, 2));
      run_op(op, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
    end

    finish_run();
  end

endmodule